// File: doc/BRIEF.md
# Activity LED blink controller

This block drives two LED pins. The first is a hardware activity LED. A transmit-activity pulse makes it run one on/off blink cycle, after which it returns to its idle level. The idle level is selectable: normally dark or normally lit. The second pin is a software LED whose state comes straight from a control bit.

Blink timing comes from a millisecond tick input. The on and off phase lengths are 8-bit millisecond counts, sampled when each phase starts. If activity arrives while a cycle is running, one further cycle is queued and starts as soon as the current cycle ends. One polarity bit sets the electrical level of both pins.

Top module: `led_blink_ctrl`

## Requirements
- R1: After reset the hardware LED is at its idle level, no cycle is queued, and both pins follow the polarity bit. Idle lit level is the inverse of `idle_off_i`.
- R2: With `idle_off_i`=1, an activity pulse sampled while idle lights the LED from the next clock. The lit phase lasts exactly max(`on_ms_i`,1) millisecond ticks. A dark phase of max(`off_ms_i`,1) ticks follows, and then the LED is idle and dark.
- R3: With `idle_off_i`=0, a cycle is a dark phase of max(`off_ms_i`,1) ticks, then a lit phase of max(`on_ms_i`,1) ticks, and then the LED is idle and lit.
- R4: Any number of activity pulses during a running cycle queue exactly one more cycle. That cycle starts in the clock right after the current cycle ends. Activity in the final clock of a cycle also queues it.
- R5: A period value of 0 behaves as a 1 ms phase.
- R6: The software LED pin shows `sw_led_i` directly, with 1 meaning lit.
- R7: With `active_high_i`=1 a lit LED drives its pin 1. With `active_high_i`=0 a lit LED drives its pin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ms_tick_i | input | 1 | One-clock pulse per millisecond |
| act_i | input | 1 | Transmit activity pulse |
| on_ms_i | input | 8 | Lit phase length, ms (default use 70) |
| off_ms_i | input | 8 | Dark phase length, ms (default use 30) |
| idle_off_i | input | 1 | 1: idle dark, 0: idle lit |
| sw_led_i | input | 1 | Software LED, 1 lit |
| active_high_i | input | 1 | Pin polarity, 1 active high |
| hw_led_o | output | 1 | Activity LED pin |
| sw_led_o | output | 1 | Software LED pin |

## Verification
The bench runs directed cases on top of random traffic. With one tick every clock, the directed cases count lit clocks for the default 70/30 timing (R2), for a normally-lit idle (R3), and for zero-length periods (R5); each count separates the correct phase length from an off-by-one. The bench also sends repeated pulses inside a running cycle, which separates "exactly one queued cycle" from both zero and several.

Random traffic uses irregular ticks, sparse activity and changing period, idle, polarity and software-LED settings. A behavioural model built from the requirements predicts both pins in every clock. This catches wrong phase order, a lost queued pulse, a wrong restart length and polarity errors.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } blink_phase_e;
endpackage

// File: rtl/ms_phase_timer.sv
module ms_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  input  logic         tick_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] len_eff;

  // zero period would stall: run it as one tick
  assign len_eff = (len_i == '0) ? W'(1) : len_i;
  assign done_o  = tick_i && (cnt_q == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= len_eff;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  p_zero_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && len_i == '0) |=> (cnt_q == W'(1)));
  p_hold_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/blink_seq.sv
module blink_seq
  import led_blink_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         act_i,
  input  logic         idle_off_i,
  input  logic [W-1:0] on_len_i,
  input  logic [W-1:0] off_len_i,
  input  logic         done_i,
  output logic         load_o,
  output logic [W-1:0] len_o,
  output logic         lit_o,
  output logic         idle_o
);
  blink_phase_e state_q, state_d;
  logic pend_q, pend_d, mode_q, mode_d;
  logic [W-1:0] first_len, second_len;

  assign first_len  = idle_off_i ? on_len_i : off_len_i;
  assign second_len = mode_q ? off_len_i : on_len_i;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    mode_d  = mode_q;
    load_o  = 1'b0;
    len_o   = first_len;
    unique case (state_q)
      PH_IDLE: begin
        pend_d = 1'b0;
        if (act_i) begin
          state_d = PH_FIRST;
          mode_d  = idle_off_i;
          load_o  = 1'b1;
        end
      end
      PH_FIRST: begin
        if (act_i) pend_d = 1'b1;
        if (done_i) begin
          state_d = PH_SECOND;
          load_o  = 1'b1;
          len_o   = second_len;
        end
      end
      PH_SECOND: begin
        if (done_i) begin
          pend_d = 1'b0;
          if (pend_q || act_i) begin
            state_d = PH_FIRST;
            mode_d  = idle_off_i;
            load_o  = 1'b1;
          end else begin
            state_d = PH_IDLE;
          end
        end else if (act_i) begin
          pend_d = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      pend_q  <= 1'b0;
      mode_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      mode_q  <= mode_d;
    end
  end

  always_comb begin
    unique case (state_q)
      PH_FIRST:  lit_o = mode_q;
      PH_SECOND: lit_o = !mode_q;
      default:   lit_o = !idle_off_i;
    endcase
  end
  assign idle_o = (state_q == PH_IDLE);

  p_start_from_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_IDLE && act_i) |=> (state_q == PH_FIRST));
  p_queued_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_SECOND && done_i && pend_q) |=> (state_q == PH_FIRST && !pend_q));
  p_no_pend_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_IDLE) |-> !pend_q);
  p_phase_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != PH_IDLE && !done_i) |=> $stable(state_q));
endmodule

// File: rtl/led_pin_drv.sv
module led_pin_drv #(
  parameter int N = 2
) (
  input  logic [N-1:0] lit_i,
  input  logic         active_high_i,
  output logic [N-1:0] pin_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    assign pin_o[g] = active_high_i ? lit_i[g] : !lit_i[g];
  end
endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ms_tick_i,
  input  logic                act_i,
  input  logic [PERIOD_W-1:0] on_ms_i,
  input  logic [PERIOD_W-1:0] off_ms_i,
  input  logic                idle_off_i,
  input  logic                sw_led_i,
  input  logic                active_high_i,
  output logic                hw_led_o,
  output logic                sw_led_o
);
  localparam int NUM_LED = 2;

  logic                load, done, hw_lit, idle;
  logic [PERIOD_W-1:0] len;
  logic [NUM_LED-1:0]  pins;

  ms_phase_timer #(.W(PERIOD_W)) i_timer (
    .clk_i, .rst_ni, .load_i(load), .len_i(len), .tick_i(ms_tick_i), .done_o(done)
  );

  blink_seq #(.W(PERIOD_W)) i_seq (
    .clk_i, .rst_ni, .act_i, .idle_off_i, .on_len_i(on_ms_i), .off_len_i(off_ms_i),
    .done_i(done), .load_o(load), .len_o(len), .lit_o(hw_lit), .idle_o(idle)
  );

  led_pin_drv #(.N(NUM_LED)) i_drv (
    .lit_i({sw_led_i, hw_lit}), .active_high_i, .pin_o(pins)
  );

  assign hw_led_o = pins[0];
  assign sw_led_o = pins[1];

  p_idle_level_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> (hw_led_o == (active_high_i ? !idle_off_i : idle_off_i)));
  p_sw_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_led_o ^ !active_high_i) == sw_led_i);
endmodule

// File: tb/test_led_blink_ctrl.sv
module test_led_blink_ctrl;
  logic clk = 0, rst_n = 0, tick = 0, act = 0;
  logic idle_off = 1, sw = 0, ah = 1;
  logic [7:0] on_ms = 8'd70, off_ms = 8'd30;
  logic hw_o, sw_o;
  bit tick_always = 0, done = 0;
  int n_cmp = 0, n_bad = 0;

  // reference model state
  int m_ph = 0, m_el = 0, m_len = 0;
  bit m_pend = 0, m_mode = 1, m_fin = 0;

  always #4 clk = ~clk;

  led_blink_ctrl i_led_blink_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(tick), .act_i(act),
    .on_ms_i(on_ms), .off_ms_i(off_ms), .idle_off_i(idle_off),
    .sw_led_i(sw), .active_high_i(ah), .hw_led_o(hw_o), .sw_led_o(sw_o)
  );

  function automatic int eff(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic logic pin_of(input logic lit);
    return ah ? lit : !lit;
  endfunction

  function automatic logic exp_hw();
    logic lit;
    lit = (m_ph == 0) ? !idle_off : ((m_ph == 1) ? m_mode : !m_mode);
    return pin_of(lit);
  endfunction

  task automatic check(input string req, input logic act_v, input logic exp_v);
    n_cmp++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act_v, exp_v, $time);
    end
  endtask

  task automatic check_int(input string req, input int act_v, input int exp_v);
    n_cmp++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_el = 0; m_pend = 0; m_mode = 1;
    end else begin
      m_fin = tick && (m_ph != 0) && (m_el + 1 == m_len);
      case (m_ph)
        0: if (act) begin
          m_ph = 1; m_mode = idle_off; m_el = 0;
          m_len = eff(idle_off ? on_ms : off_ms);
        end
        1: begin
          if (act) m_pend = 1;
          if (m_fin) begin
            m_ph = 2; m_el = 0; m_len = eff(m_mode ? off_ms : on_ms);
          end else if (tick) m_el++;
        end
        default: begin
          if (m_fin) begin
            if (m_pend || act) begin
              m_ph = 1; m_mode = idle_off; m_el = 0;
              m_len = eff(idle_off ? on_ms : off_ms);
            end else m_ph = 0;
            m_pend = 0;
          end else begin
            if (tick) m_el++;
            if (act) m_pend = 1;
          end
        end
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (!done) begin
    string tag;
    tag = (m_ph == 0) ? "R1 R7" : (m_mode ? "R2 R7" : "R3 R7");
    check(tag, hw_o, exp_hw());
    check("R6", sw_o, pin_of(sw));
  end

  initial forever begin
    @(posedge clk); #1;
    tick = tick_always ? 1'b1 : (($urandom % 3) == 0);
  end

  task automatic pulse();
    @(posedge clk); #1 act = 1;
    @(posedge clk); #1 act = 0;
  endtask

  task automatic count_lit(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if ((hw_o ^ !ah) == 1'b1) c++;
    end
  endtask

  initial begin
    int c;
    void'($urandom(32'h1ed5));
    repeat (3) @(negedge clk);
    check("R1", hw_o, 1'b0);       // idle dark, active high
    check("R6", sw_o, 1'b0);
    #1 rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1", hw_o, 1'b0);

    // R2 default timing, one tick every clock
    tick_always = 1;
    repeat (2) @(posedge clk);
    pulse();
    count_lit(200, c);
    check_int("R2 lit clocks", c, 70);

    // R3 normally lit
    #1 idle_off = 0; on_ms = 4; off_ms = 6;
    pulse();
    count_lit(40, c);
    check_int("R3 dark clocks", 40 - c, 6);

    // R5 zero periods
    #1 idle_off = 1; on_ms = 0; off_ms = 0;
    repeat (3) @(posedge clk);
    pulse();
    count_lit(10, c);
    check_int("R5 lit clocks", c, 1);

    // R4 repeated pulses inside a running cycle
    #1 on_ms = 3; off_ms = 2;
    pulse();
    c = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (hw_o) c++;
      @(posedge clk); #1 act = (i == 0 || i == 2);
    end
    #1 act = 0;
    check_int("R4 lit clocks", c, 6);

    // R6 and R7 directed
    @(posedge clk); #1 ah = 0; sw = 1;
    @(negedge clk);
    check("R6 sw lit low", sw_o, 1'b0);
    check("R7 idle dark low", hw_o, 1'b1);
    @(posedge clk); #1 ah = 1;

    // random traffic
    tick_always = 0;
    for (int i = 0; i < 12000; i++) begin
      @(posedge clk); #1;
      act = (($urandom % 25) == 0);
      if (i % 60 == 0) begin sw = $urandom; ah = $urandom; end
      if (i % 700 == 0) begin
        on_ms = $urandom % 7; off_ms = $urandom % 7; idle_off = $urandom;
      end
    end
    #1 act = 0;
    repeat (100) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule